// File: doc/BRIEF.md
# Reset-Conditioned Memory Chip-Enable Gate

This block sits between a memory controller's active-low chip-enable and an external memory that must not be written while the system is held in reset. When the supervisor reports no reset, the enable passes straight through to the conditioned output. While reset is asserted, no new access reaches the memory. An access that is already running when reset arrives may finish within a bounded grace window. The window closes when the raw enable returns high or when a cycle budget is used up, whichever comes first. After it closes, the output stays inactive until reset clears.

A mode input turns the gating off. The output is then forced to its inactive (high) level, which stands in for a pulled-up output that nobody drives. The grace budget is set as a time in nanoseconds and a clock frequency, and the design converts it to clock cycles. The defaults give 15 us at 200 MHz, which is 3000 cycles.

Top module: `ce_cond_gate`

## Requirements
- R1: While `gate_en` is 0 (disabled mode), `ce_out_n` is 1 in the same cycle, whatever the other inputs are.
- R2: While `gate_en` is 1 and `sys_rst` is 0, `ce_out_n` equals `ce_raw_n` in the same cycle (combinational pass-through).
- R3: In a cycle with `sys_rst` at 1, `ce_out_n` is 1 whenever `ce_out_n` was 1 in the previous cycle, so a falling raw enable during reset never reaches the output.
- R4: If `ce_out_n` was 0 in the cycle before `sys_rst` rises, and `ce_raw_n` stays 0, `ce_out_n` stays 0 in the cycles after the rise.
- R5: The grace window ends in the first reset cycle in which `ce_raw_n` is 1. `ce_out_n` then stays 1 for the rest of that reset, even if `ce_raw_n` goes low again.
- R6: During one reset, `ce_out_n` is 0 for at most GRACE_CYC cycles, counting the cycle in which `sys_rst` rises. It is 1 from then until reset clears. GRACE_CYC = ceil(GRACE_NS * CLK_MHZ / 1000), with a minimum of 1.
- R7: In the first cycle with `sys_rst` back at 0, `ce_out_n` again follows `ce_raw_n`, so a low raw enable passes through at once.
- R8: While `rst_n` is 0, `ce_out_n` is 1. After `rst_n` is released, no grace window is carried over from before the block reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| ce_raw_n | input | 1 | Raw active-low chip-enable from the memory controller |
| sys_rst | input | 1 | Reset status from the supervisor, 1 = system reset asserted |
| gate_en | input | 1 | Mode: 1 = gating active, 0 = output forced inactive |
| ce_out_n | output | 1 | Conditioned active-low chip-enable to the memory |

## Verification
Directed sequences cover four cases, and each one separates two behaviours:
- An access running when reset rises that releases early tells grace continuation (R4) apart from the early end (R5).
- An access held low past the budget marks the exact cycle where the limit bites (R6).
- A raw enable that falls during reset shows that a new access is blocked (R3), and a low after the grace ends shows that no access is re-admitted (R5).
- A low enable at the moment reset clears shows the immediate resumption (R7).

Random stimulus then toggles the raw enable often, reset rarely and the mode very rarely. This lands disabled-mode entries and block resets in the middle of a grace window. A bench model built from the requirements predicts every cycle.

// File: rtl/cegate_pkg.sv
package cegate_pkg;

  // Convert a duration in ns to whole clock cycles (rounded up, at least 1).
  function automatic int ns_to_cycles(input int dur_ns, input int clk_mhz);
    int cyc;
    cyc = (dur_ns * clk_mhz + 999) / 1000;
    if (cyc < 1) cyc = 1;
    return cyc;
  endfunction

  // Width of a counter that must reach the value lim.
  function automatic int cnt_width(input int lim);
    int w;
    w = $clog2(lim + 1);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/cegate_prev_track.sv
// Remembers whether the conditioned enable was active in the previous cycle.
module cegate_prev_track (
  input  logic clk,
  input  logic rst_n,
  input  logic out_low,
  output logic prev_low
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = out_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign prev_low = prev_q;

endmodule

// File: rtl/cegate_grace_timer.sv
// Counts active cycles of the conditioned enable within one reset period
// and grants continuation while the budget is not used up.
module cegate_grace_timer #(
  parameter int GRACE_CYC = 3000,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst,
  input  logic             out_low,
  input  logic             prev_low,
  output logic             allow,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GRACE_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             in_grace;

  always_comb begin
    in_grace = sys_rst & out_low;
    cnt_en   = in_grace | (cnt_q != '0);
    cnt_d    = in_grace ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    allow = prev_low & (cnt_q < LIMIT);
  end

  assign cnt_o = cnt_q;

  // R6: an active reset cycle advances the budget count by exactly one
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && out_low) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R6: the count never passes the budget
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

endmodule

// File: rtl/ce_cond_gate.sv
module ce_cond_gate #(
  parameter int CLK_MHZ  = 200,
  parameter int GRACE_NS = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_raw_n,
  input  logic sys_rst,
  input  logic gate_en,
  output logic ce_out_n
);

  localparam int GRACE_CYC = cegate_pkg::ns_to_cycles(GRACE_NS, CLK_MHZ);
  localparam int CNT_W     = cegate_pkg::cnt_width(GRACE_CYC);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GRACE_CYC);

  logic             out_low;
  logic             prev_low;
  logic             allow;
  logic [CNT_W-1:0] grace_cnt;

  cegate_prev_track u_prev (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_low  (out_low),
    .prev_low (prev_low)
  );

  cegate_grace_timer #(
    .GRACE_CYC (GRACE_CYC),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_rst  (sys_rst),
    .out_low  (out_low),
    .prev_low (prev_low),
    .allow    (allow),
    .cnt_o    (grace_cnt)
  );

  // Active-low output: active only with gating on, block out of reset,
  // raw enable active, and either no system reset or a live grace window.
  always_comb begin
    out_low  = rst_n & gate_en & ~ce_raw_n & (~sys_rst | allow);
    ce_out_n = ~out_low;
  end

  // R1: disabled mode forces the output inactive
  a_r1_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> ce_out_n);

  // R2: pass-through outside reset
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !sys_rst) |-> (ce_out_n == ce_raw_n));

  // R3: an inactive output cannot become active while reset is asserted
  a_r3_no_new_access: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && $past(ce_out_n)) |-> ce_out_n);

  // R6: once the budget is spent the output stays inactive in reset
  a_r6_budget_spent: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && grace_cnt == LIMIT) |-> ce_out_n);

endmodule

// File: tb/ce_cond_gate_tb_top.sv
`timescale 1ns/1ps
module ce_cond_gate_tb_top;

  localparam int CLK_MHZ  = 200;
  localparam int GRACE_NS = 200;
  localparam int G        = (GRACE_NS * CLK_MHZ + 999) / 1000; // 40 cycles

  logic clk;
  logic rst_n;
  logic ce_raw_n;
  logic sys_rst;
  logic gate_en;
  logic ce_out_n;

  int total;
  int bad;
  bit finished;

  // bench model state
  bit m_prev_low;
  int m_cnt;
  bit m_prev_sys;

  ce_cond_gate #(.CLK_MHZ(CLK_MHZ), .GRACE_NS(GRACE_NS)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_raw_n (ce_raw_n),
    .sys_rst  (sys_rst),
    .gate_en  (gate_en),
    .ce_out_n (ce_out_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit exp_out_n(bit rn, bit en, bit raw_n, bit sys,
                                   bit prev_low, int cnt);
    bit low;
    low = rn & en & ~raw_n & (~sys | (prev_low & (cnt < G)));
    return ~low;
  endfunction

  function automatic string req_tag(bit rn, bit en, bit raw_n, bit sys,
                                    bit prev_low, int cnt, bit prev_sys);
    if (!rn) return "R8";
    if (!en) return "R1";
    if (!sys) return prev_sys ? "R7" : "R2";
    if (!prev_low) return "R3";
    if (cnt >= G) return "R6";
    if (raw_n) return "R5";
    return "R4";
  endfunction

  // Apply one cycle of inputs, check the output, advance the model.
  task automatic step(bit rn, bit en, bit raw_n, bit sys);
    bit e;
    string t;
    @(negedge clk);
    rst_n = rn; gate_en = en; ce_raw_n = raw_n; sys_rst = sys;
    #1;
    e = exp_out_n(rn, en, raw_n, sys, m_prev_low, m_cnt);
    t = req_tag(rn, en, raw_n, sys, m_prev_low, m_cnt, m_prev_sys);
    total++;
    if (ce_out_n !== e) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", t, $time, ce_out_n, e);
    end
    @(posedge clk);
    if (!rn) begin
      m_prev_low = 1'b0; m_cnt = 0; m_prev_sys = 1'b0;
    end else begin
      m_prev_low = ~e;
      m_cnt      = (sys && !e) ? m_cnt + 1 : 0;
      m_prev_sys = sys;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit en, raw, sys, rn;
    total = 0; bad = 0; finished = 0;
    m_prev_low = 0; m_cnt = 0; m_prev_sys = 0;
    rst_n = 0; gate_en = 1; ce_raw_n = 0; sys_rst = 0;
    // R8: block reset holds output inactive even with raw low
    repeat (3) step(0, 1, 0, 0);
    step(1, 1, 1, 0);
    // R2: pass-through
    step(1, 1, 0, 0); step(1, 1, 1, 0); step(1, 1, 0, 0);
    // R4 then R5: grace continues, ends on raw high, later low ignored
    repeat (5) step(1, 1, 0, 1);
    step(1, 1, 1, 1);
    repeat (4) step(1, 1, 0, 1);
    // R7: resume at once after reset clears
    step(1, 1, 0, 0);
    // R6: budget exhausted with raw held low
    repeat (G + 10) step(1, 1, 0, 1);
    step(1, 1, 0, 0); step(1, 1, 1, 0);
    // R3: new access during reset blocked
    step(1, 1, 1, 1);
    repeat (3) step(1, 1, 0, 1);
    step(1, 1, 1, 0);
    // R1: disabled mode, including mid-grace
    step(1, 0, 0, 0); step(1, 1, 0, 0);
    step(1, 1, 0, 1); step(1, 0, 0, 1); step(1, 1, 0, 1);
    step(1, 1, 0, 0);
    // R8: block reset in the middle of a grace window, no carry-over
    step(1, 1, 0, 1); step(0, 1, 0, 1); step(1, 1, 0, 1);
    step(1, 1, 0, 0);
    // constrained random
    void'($urandom(32'd20240611));
    en = 1; raw = 1; sys = 0; rn = 1;
    for (int i = 0; i < 8000; i++) begin
      if ($urandom_range(0, 3) == 0) raw = ~raw;
      if ($urandom_range(0, 49) == 0) sys = ~sys;
      if ($urandom_range(0, 199) == 0) en = ~en;
      rn = ($urandom_range(0, 499) != 0);
      if (i % 700 < 60 && sys) raw = 0; // long lows to reach the budget
      step(rn, en, raw, sys);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule